// File: doc/BRIEF.md
# Collision Backoff Timer

This block decides how long a half-duplex transmitter waits after a collision before it tries again. Each collision pulse raises a saturating collision count. The block then takes a pseudo-random number of slot times from a window whose size depends on that count. It counts the number down on slot-time ticks and gives a single-cycle retry pulse when the wait is over. A success pulse from the transmitter returns the count to zero and drops any wait still in progress.

A low-priority input widens the window for the first three collisions of a frame. In that mode the node tends to wait longer than normal stations, so it usually loses contention against them. From the fourth collision on, both modes use the same window. The count is available at a port, and a flag shows when it has reached its ceiling, so the logic around the block can apply its own retry limit.

Top module: `backoff_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, `coll_cnt_o` is 0 and `excess_o`, `busy_o` and `retry_o` are all low.
- R2: A collision pulse without a success pulse raises `coll_cnt_o` by one on the next cycle. The count stops at 16, and `excess_o` is high exactly while the count is 16.
- R3: A success pulse sets the count to 0, drops `busy_o` and cancels any pending retry on the next cycle. If it arrives in the same cycle as a collision pulse, the success pulse wins.
- R4: The random source is a 16-bit shift register. Reset loads it with 16'hACE1. On every clock after reset it shifts left, and the new bit 0 is the XOR of bits 15, 13, 12 and 10. The wait drawn at a collision is the register value present in that cycle, with every bit at or above the exponent cleared.
- R5: With the low-priority input low, the exponent after collision n is min(n, 10), so the wait lies in 0 to 2^min(n,10) - 1 slot times.
- R6: With the low-priority input high at collision n, and n at most 3, the exponent is n + 3 (at most 10).
- R7: With the low-priority input high at collision n, and n 4 or more, the exponent falls back to min(n, 10).
- R8: After a collision that draws wait d, `busy_o` is high from the next cycle on. `retry_o` is a one-cycle pulse in the cycle after the (d+1)-th slot tick. In that same cycle `busy_o` is low, so a wait of 0 gives a retry after the first tick.
- R9: Slot ticks do nothing while idle. A collision during a wait starts a new draw. A tick in the same cycle as a collision is ignored.
- R10: At the saturated count, further collisions still draw waits with exponent 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| coll_i | input | 1 | One-cycle collision pulse |
| tx_ok_i | input | 1 | One-cycle success pulse; clears the count and any wait |
| offset_en_i | input | 1 | Low-priority mode, sampled with each collision |
| slot_tick_i | input | 1 | One-cycle pulse per slot time |
| retry_o | output | 1 | One-cycle pulse when the wait has elapsed |
| busy_o | output | 1 | High while a wait is counting down |
| coll_cnt_o | output | 5 | Collisions since the last success, saturating at 16 |
| excess_o | output | 1 | High while the count is saturated |

## Verification
The bench keeps its own model of the shift register. From it, it works out the exact wait each collision should draw. It then counts slot ticks up to the retry, so a wrong exponent, a wrong mask or an off-by-one in the countdown each shows up as a retry on the wrong tick. Collision runs are tried in normal mode from 1 to 17, which covers the cap at 10 and saturation at 16. Offset runs from 1 to 5 separate the widened window from the fall-back, and random mixes with idle gaps between ticks follow. Directed cases cover ticks while idle, a collision landing on a tick, a re-collision during a wait, and a success pulse during a wait or together with a collision. Together they show that each input takes its stated priority.

// File: rtl/backoff_pkg.sv
// Shared types for the collision backoff timer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package backoff_pkg;

    // Countdown state: idle or waiting for slot ticks.
    typedef enum logic {
        BO_IDLE = 1'b0,
        BO_WAIT = 1'b1
    } bo_state_e;

    // Saturating increment of a collision count.
    function automatic int unsigned sat_inc(input int unsigned val, input int unsigned ceil);
        return (val >= ceil) ? ceil : val + 1;
    endfunction

    // Smaller of two integers.
    function automatic int unsigned umin(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/bo_lfsr.sv
// Free-running Fibonacci shift register used as the random source.
// It shifts left on every clock, and the new bit 0 is the XOR of the bits
// selected by TAPS. Only the low OUT_W bits are exported.
// Assumes: TAPS describes a maximal-length polynomial and SEED is nonzero.
module bo_lfsr #(
    parameter int          W     = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1,
    parameter int          OUT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd_o
);

    logic [W-1:0] q;
    logic         fb;

    // Feedback bit from the tapped positions.
    always_comb begin
        fb = ^(q & TAPS);
    end

    // Advance one step per clock, reload the seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= SEED;
        end else begin
            q <= {q[W-2:0], fb};
        end
    end

    assign rnd_o = q[OUT_W-1:0];

endmodule

// File: rtl/bo_coll_counter.sv
// Saturating collision counter with an excess flag.
// It also gives the next count combinationally, so the range selector can
// size the window in the same cycle as the collision.
// Assumes: clear has priority over a collision in the same cycle.
module bo_coll_counter
    import backoff_pkg::*;
#(
    parameter int CNT_MAX = 16,
    parameter int CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             coll_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             excess_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             excess_q;

    // Next count: clear wins, otherwise a collision raises it up to the ceiling.
    always_comb begin
        if (clear_i) begin
            cnt_next_o = '0;
        end else if (coll_i) begin
            cnt_next_o = CNT_W'(sat_inc(int'(cnt_q), CNT_MAX));
        end else begin
            cnt_next_o = cnt_q;
        end
    end

    // Register the count and the saturation flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            excess_q <= 1'b0;
        end else begin
            cnt_q    <= cnt_next_o;
            excess_q <= (cnt_next_o == CNT_W'(CNT_MAX));
        end
    end

    assign cnt_o    = cnt_q;
    assign excess_o = excess_q;

endmodule

// File: rtl/bo_range_sel.sv
// Picks the backoff exponent from the collision number and the priority mode,
// then masks the random word down to that many low bits.
// Assumes: n is the count after the current collision (1 or more at a collision).
module bo_range_sel
    import backoff_pkg::*;
#(
    parameter int CNT_W     = 5,
    parameter int MAX_EXP   = 10,
    parameter int OFS_COLLS = 3,
    parameter int OFS_ADD   = 3,
    parameter int EXP_W     = 4
) (
    input  logic [CNT_W-1:0]   n_i,
    input  logic               offset_en_i,
    input  logic [MAX_EXP-1:0] rnd_i,
    output logic [MAX_EXP-1:0] delay_o
);

    logic [EXP_W-1:0]   exp_w;
    logic [MAX_EXP-1:0] mask;

    // Exponent: widened by OFS_ADD for early collisions in offset mode, capped.
    always_comb begin
        int unsigned n_u;
        int unsigned raw;
        n_u = int'(n_i);
        if (offset_en_i && (n_u <= OFS_COLLS)) begin
            raw = n_u + OFS_ADD;
        end else begin
            raw = n_u;
        end
        exp_w = EXP_W'(umin(raw, MAX_EXP));
    end

    // One mask bit per position: kept when below the exponent.
    for (genvar g = 0; g < MAX_EXP; g++) begin : g_mask
        assign mask[g] = (int'(exp_w) > g);
    end

    assign delay_o = rnd_i & mask;

endmodule

// File: rtl/bo_countdown.sv
// Slot-time countdown. A load starts a wait of the given length. Each slot
// tick then takes one step, and the tick that finds zero ends the wait with
// a one-cycle retry pulse.
// Assumes: clear has priority over load, and load has priority over tick.
module bo_countdown
    import backoff_pkg::*;
#(
    parameter int DELAY_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               clear_i,
    input  logic               tick_i,
    input  logic [DELAY_W-1:0] delay_i,
    output logic               busy_o,
    output logic               retry_o
);

    bo_state_e          state_q;
    logic [DELAY_W-1:0] remain_q;
    logic               retry_q;

    // Wait state machine with the remaining slot count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= BO_IDLE;
            remain_q <= '0;
            retry_q  <= 1'b0;
        end else begin
            retry_q <= 1'b0;
            if (clear_i) begin
                state_q  <= BO_IDLE;
                remain_q <= '0;
            end else if (load_i) begin
                state_q  <= BO_WAIT;
                remain_q <= delay_i;
            end else if ((state_q == BO_WAIT) && tick_i) begin
                if (remain_q == '0) begin
                    state_q <= BO_IDLE;
                    retry_q <= 1'b1;
                end else begin
                    remain_q <= remain_q - 1'b1;
                end
            end
        end
    end

    assign busy_o  = (state_q == BO_WAIT);
    assign retry_o = retry_q;

endmodule

// File: rtl/backoff_gen.sv
// Collision backoff timer top level.
// It connects the random source, the collision counter, the range selector
// and the countdown. A collision pulse draws a new wait; a success pulse
// clears the count and the wait.
// Assumes: all inputs are synchronous one-cycle pulses, except offset_en_i,
// which is a level sampled with each collision.
module backoff_gen #(
    parameter int          LFSR_W    = 16,
    parameter logic [15:0] LFSR_TAPS = 16'hB400,
    parameter logic [15:0] LFSR_SEED = 16'hACE1,
    parameter int          MAX_EXP   = 10,
    parameter int          CNT_MAX   = 16,
    parameter int          OFS_COLLS = 3,
    parameter int          OFS_ADD   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       coll_i,
    input  logic       tx_ok_i,
    input  logic       offset_en_i,
    input  logic       slot_tick_i,
    output logic       retry_o,
    output logic       busy_o,
    output logic [4:0] coll_cnt_o,
    output logic       excess_o
);

    localparam int CNT_W = $clog2(CNT_MAX + 1);
    localparam int EXP_W = $clog2(MAX_EXP + 1);

    logic [MAX_EXP-1:0] rnd;
    logic [MAX_EXP-1:0] delay;
    logic [CNT_W-1:0]   cnt_next;
    logic [CNT_W-1:0]   cnt_q;
    logic               coll_take;

    // A collision is taken only when no success pulse arrives in the same cycle.
    always_comb begin
        coll_take = coll_i && !tx_ok_i;
    end

    bo_lfsr #(
        .W     (LFSR_W),
        .TAPS  (LFSR_TAPS[LFSR_W-1:0]),
        .SEED  (LFSR_SEED[LFSR_W-1:0]),
        .OUT_W (MAX_EXP)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd_o (rnd)
    );

    bo_coll_counter #(
        .CNT_MAX (CNT_MAX),
        .CNT_W   (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .coll_i     (coll_i),
        .clear_i    (tx_ok_i),
        .cnt_next_o (cnt_next),
        .cnt_o      (cnt_q),
        .excess_o   (excess_o)
    );

    bo_range_sel #(
        .CNT_W     (CNT_W),
        .MAX_EXP   (MAX_EXP),
        .OFS_COLLS (OFS_COLLS),
        .OFS_ADD   (OFS_ADD),
        .EXP_W     (EXP_W)
    ) u_range (
        .n_i         (cnt_next),
        .offset_en_i (offset_en_i),
        .rnd_i       (rnd),
        .delay_o     (delay)
    );

    bo_countdown #(
        .DELAY_W (MAX_EXP)
    ) u_cd (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (coll_take),
        .clear_i (tx_ok_i),
        .tick_i  (slot_tick_i),
        .delay_i (delay),
        .busy_o  (busy_o),
        .retry_o (retry_o)
    );

    assign coll_cnt_o = 5'(cnt_q);

endmodule

// File: rtl/backoff_gen_chk.sv
// Checker for the collision backoff timer, bound to the top level.
// It watches only the ports and their relations over time.
module backoff_gen_chk #(
    parameter int CNT_MAX = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       coll_i,
    input logic       tx_ok_i,
    input logic       slot_tick_i,
    input logic       retry_o,
    input logic       busy_o,
    input logic [4:0] coll_cnt_o,
    input logic       excess_o
);

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_i && !tx_ok_i) |=> (coll_cnt_o == (($past(coll_cnt_o) == 5'(CNT_MAX)) ?
                                   5'(CNT_MAX) : $past(coll_cnt_o) + 5'd1)));

    // R2
    cnt_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_cnt_o <= 5'(CNT_MAX)) && (excess_o == (coll_cnt_o == 5'(CNT_MAX))));

    // R3
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ok_i |=> ((coll_cnt_o == 5'd0) && !busy_o && !retry_o));

    // R8
    retry_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry_o |=> !retry_o);

    // R8
    retry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(retry_o) |-> ($past(busy_o) && $past(slot_tick_i) && !busy_o));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !coll_i) |=> (!busy_o && !retry_o));

    // R8
    load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_i && !tx_ok_i) |=> (busy_o && !retry_o));

endmodule

bind backoff_gen backoff_gen_chk #(.CNT_MAX(CNT_MAX)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .coll_i      (coll_i),
    .tx_ok_i     (tx_ok_i),
    .slot_tick_i (slot_tick_i),
    .retry_o     (retry_o),
    .busy_o      (busy_o),
    .coll_cnt_o  (coll_cnt_o),
    .excess_o    (excess_o)
);

// File: tb/backoff_gen_tb.sv
// Self-checking bench for backoff_gen: directed corners plus seeded random rounds.
module backoff_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       coll_i = 1'b0;
    logic       tx_ok_i = 1'b0;
    logic       offset_en_i = 1'b0;
    logic       slot_tick_i = 1'b0;
    logic       retry_o;
    logic       busy_o;
    logic [4:0] coll_cnt_o;
    logic       excess_o;

    int checks = 0;
    int failures = 0;
    int exp_cnt = 0;
    bit done = 1'b0;

    logic [15:0] m_lfsr;
    logic [15:0] m_cap;

    backoff_gen u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .coll_i      (coll_i),
        .tx_ok_i     (tx_ok_i),
        .offset_en_i (offset_en_i),
        .slot_tick_i (slot_tick_i),
        .retry_o     (retry_o),
        .busy_o      (busy_o),
        .coll_cnt_o  (coll_cnt_o),
        .excess_o    (excess_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference random source as stated in R4; captures the value seen at each taken collision.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lfsr <= 16'hACE1;
        end else begin
            m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
            if (coll_i && !tx_ok_i) m_cap <= m_lfsr;
        end
    end

    function automatic int exp_of(bit off, int n);
        int e;
        e = (off && n <= 3) ? n + 3 : n;
        return (e > 10) ? 10 : e;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; coll_i = 0; tx_ok_i = 0; slot_tick_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_cnt = 0;
    endtask

    // Collide once; returns the expected wait drawn.
    task automatic collide(input bit off, input bit with_tick, input string req, output int d);
        int e;
        @(negedge clk);
        coll_i = 1'b1; offset_en_i = off; slot_tick_i = with_tick;
        @(negedge clk);
        coll_i = 1'b0; slot_tick_i = 1'b0;
        exp_cnt = (exp_cnt >= 16) ? 16 : exp_cnt + 1;
        e = exp_of(off, exp_cnt);
        d = int'(m_cap) & ((1 << e) - 1);
        chk(coll_cnt_o == 5'(exp_cnt), {req, " R2 count"}, int'(coll_cnt_o), exp_cnt);
        chk(excess_o == (exp_cnt == 16), {req, " R2 excess"}, int'(excess_o), int'(exp_cnt == 16));
        chk(busy_o == 1'b1 && retry_o == 1'b0, {req, " R8 busy after collision"}, int'(busy_o), 1);
    endtask

    // Issue ticks until the retry; checks that it lands after tick d+1 exactly.
    task automatic run_wait(input int d, input bit gaps, input string req);
        int got;
        got = -1;
        for (int k = 0; k <= d; k++) begin
            if (gaps && ($urandom % 4 == 0)) begin
                @(negedge clk);
                if (retry_o && got < 0) got = 5000;
            end
            slot_tick_i = 1'b1;
            @(negedge clk);
            slot_tick_i = 1'b0;
            if (retry_o && got < 0) got = k;
        end
        chk(got == d, {req, " R8 retry tick index"}, got, d);
        chk(busy_o == 1'b0, {req, " R8 busy low at retry"}, int'(busy_o), 0);
        @(negedge clk);
        chk(retry_o == 1'b0, {req, " R8 retry one cycle"}, int'(retry_o), 0);
    endtask

    task automatic pulse_ok();
        @(negedge clk);
        tx_ok_i = 1'b1;
        @(negedge clk);
        tx_ok_i = 1'b0;
        exp_cnt = 0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int d;
        int d2;
        process::self().srandom(32'd20240);
        void'($urandom(32'd20240));
        do_reset();
        // R1 first cycle after reset
        chk(coll_cnt_o == 0 && !excess_o && !busy_o && !retry_o, "R1 reset state",
            int'({coll_cnt_o, excess_o, busy_o, retry_o}), 0);

        // R9 ticks while idle
        for (int i = 0; i < 4; i++) begin
            slot_tick_i = 1'b1; @(negedge clk); slot_tick_i = 1'b0;
            chk(!retry_o && !busy_o, "R9 idle tick", int'({busy_o, retry_o}), 0);
        end

        // R5 R10 normal mode collisions 1..17
        for (int n = 1; n <= 17; n++) begin
            collide(1'b0, 1'b0, "R5 normal", d);
            run_wait(d, 1'b0, (n >= 16) ? "R10 saturated" : "R5 normal");
        end

        // R3 clear during wait
        collide(1'b0, 1'b0, "R3 pre", d);
        pulse_ok();
        chk(coll_cnt_o == 0 && !busy_o, "R3 clear during wait", int'(coll_cnt_o), 0);
        for (int i = 0; i < 3; i++) begin
            slot_tick_i = 1'b1; @(negedge clk); slot_tick_i = 1'b0;
            chk(!retry_o, "R3 no retry after clear", int'(retry_o), 0);
        end

        // R6 R7 offset mode collisions 1..5
        for (int n = 1; n <= 5; n++) begin
            collide(1'b1, 1'b0, (n <= 3) ? "R6 offset" : "R7 offset fallback", d);
            run_wait(d, 1'b1, (n <= 3) ? "R6 offset" : "R7 offset fallback");
        end
        pulse_ok();

        // R9 collision together with a tick
        collide(1'b0, 1'b1, "R9 coll+tick", d);
        run_wait(d, 1'b0, "R9 coll+tick");

        // R9 re-collision during wait draws anew
        collide(1'b1, 1'b0, "R9 first", d);
        @(negedge clk);
        collide(1'b1, 1'b0, "R9 restart", d2);
        run_wait(d2, 1'b0, "R9 restart");

        // R3 success and collision in the same cycle
        @(negedge clk);
        tx_ok_i = 1'b1; coll_i = 1'b1;
        @(negedge clk);
        tx_ok_i = 1'b0; coll_i = 1'b0; exp_cnt = 0;
        chk(coll_cnt_o == 0 && !busy_o, "R3 success beats collision", int'(coll_cnt_o), 0);

        // R4 R5 R6 random mix
        for (int r = 0; r < 14; r++) begin
            bit off;
            off = 1'($urandom % 2);
            if ($urandom % 3 == 0) pulse_ok();
            collide(off, 1'($urandom % 2), "R4 random", d);
            run_wait(d, 1'b1, "R4 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule